// File: doc/BRIEF.md
# Convolver Configuration Register File

This block is the host-facing configuration store of a 3 x 3 image convolution engine. A host presents a 3-bit register address, a 10-bit data word, a chip select and a load strobe. The strobe is brought into the system clock domain, and a write is committed when its synchronized copy falls. The address picks one of the following actions: load the row length, load the pixel ALU command word, load the initialization word, push one coefficient into kernel bank 0 or bank 1, make bank 0 or bank 1 the active kernel, or do nothing.

Each bank holds nine 8-bit coefficients, named A to I. Writes to a bank's address fill that bank one tap at a time through its own tap pointer. The nine coefficients of the active bank are driven out in parallel and change on the clock that follows the select write. Because of this, a host can refill the idle bank while the datapath runs and then switch banks without a gap.

After reset there is a fixed window of clock cycles during which the row length can be loaded once. When the window closes, the register is frozen.

Top module: `conv_cfg_regfile`

## Requirements
- R1: While reset is asserted and right after it ends, the row length reads 0 (meaning 1024), the ALU command reads 0x018 (pass pixel unchanged, no shift), the initialization word reads 0, bank 0 is active and all coefficient outputs read 0.
- R2: A write is committed when the synchronized load strobe falls, using the address, data and chip select held while the strobe was high. If chip select was low, no output changes.
- R3: Address 1 loads the 10-bit ALU command, and address 4 loads the 9-bit initialization word from data bits 8:0.
- R4: Each write to address 2 (bank 0) or address 3 (bank 1) stores data bits 7:0 into that bank at its tap pointer, then advances the pointer A, B, ... I. After I the pointer wraps back to A.
- R5: A write to one bank's address returns the other bank's tap pointer to A.
- R6: A write to address 5 makes bank 0 active, and a write to address 6 makes bank 1 active, from the next clock. The coefficient output carries the active bank with tap A in bits 7:0 through tap I in bits 71:64.
- R7: Address 0 loads data bits 9:0 into the row length only for the first such write after reset, and only if it commits on one of clock edges 1 to 1024 counted from reset release. Any later write is ignored and the held value stays.
- R8: The initialization outputs decode the stored word as follows: bit 0 is the external-line mode, bits 2:1 the input delay count, bit 3 signed pixels, bit 4 signed coefficients, bits 6:5 the rounding mode and bits 8:7 the cascade shift code.
- R9: A write to address 7 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | 3 | Register address |
| hostData | input | 10 | Write data |
| hostSel | input | 1 | Chip select, active high |
| hostLoad | input | 1 | Load strobe; write commits after its falling edge |
| rowLen | output | 10 | Row length, 0 meaning 1024 |
| aluCode | output | 10 | Pixel ALU command word |
| extLineMode | output | 1 | Multipliers fed from external line buffers |
| inDelay | output | 2 | Extra input pipeline stages |
| pixSigned | output | 1 | Pixels are two's complement |
| coefSigned | output | 1 | Coefficients are two's complement |
| roundMode | output | 2 | Output rounding selection |
| casShift | output | 2 | Cascade input shift code |
| bankSel | output | 1 | Active coefficient bank |
| coefActive | output | 72 | Active bank coefficients, tap A in the low byte |

## Verification
Two events can land on the same clock edge: the closing of the row-length window and a row-length write committing. The bench counts clock edges from reset release and times the strobe so the write commits exactly on edge 1024 in one reset session and on edge 1025 in another. The first write must be kept and the second must leave the length at 0. A checker also ensures the length never moves once the window has closed.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  localparam int ADDR_W = 3;
  localparam int INIT_W = 9;

  typedef enum logic [ADDR_W-1:0] {
    ADR_ROW   = 3'd0,
    ADR_ALU   = 3'd1,
    ADR_BANK0 = 3'd2,
    ADR_BANK1 = 3'd3,
    ADR_INIT  = 3'd4,
    ADR_SEL0  = 3'd5,
    ADR_SEL1  = 3'd6,
    ADR_NOP   = 3'd7
  } cfgAddr_e;

  // One-cycle write strobes from control to the register store
  typedef struct packed {
    logic       wrRow;
    logic       wrAlu;
    logic [1:0] wrBank;
    logic       wrInit;
    logic [1:0] selBank;
  } cfgStrobe_t;

endpackage

// File: rtl/cfg_host_ctrl.sv
module cfg_host_ctrl
  import cfg_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [DATA_W-1:0]    hostData,
  input  logic                 hostSel,
  input  logic                 hostLoad,
  output cfgStrobe_t           strb,
  output logic [DATA_W-1:0]    wrData
);

  localparam int SYNC_N = 3;

  logic [SYNC_N-1:0] loadPipe;
  logic [ADDR_W-1:0] capAddr;
  logic              capSel;
  logic              loadFall;

  // Two synchronizer stages plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loadPipe <= '0;
    else       loadPipe <= {loadPipe[SYNC_N-2:0], hostLoad};
  end

  assign loadFall = loadPipe[SYNC_N-1] & ~loadPipe[SYNC_N-2];

  // Host fields are captured while the synchronized strobe is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr <= '0;
      capSel  <= 1'b0;
      wrData  <= '0;
    end else if (loadPipe[SYNC_N-2]) begin
      capAddr <= hostAddr;
      capSel  <= hostSel;
      wrData  <= hostData;
    end
  end

  always_comb begin
    strb = '0;
    if (loadFall && capSel) begin
      unique case (cfgAddr_e'(capAddr))
        ADR_ROW:   strb.wrRow      = 1'b1;
        ADR_ALU:   strb.wrAlu      = 1'b1;
        ADR_BANK0: strb.wrBank[0]  = 1'b1;
        ADR_BANK1: strb.wrBank[1]  = 1'b1;
        ADR_INIT:  strb.wrInit     = 1'b1;
        ADR_SEL0:  strb.selBank[0] = 1'b1;
        ADR_SEL1:  strb.selBank[1] = 1'b1;
        default:   strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
  import cfg_pkg::*;
#(
  parameter int          DATA_W     = 10,
  parameter int          COEF_W     = 8,
  parameter int          TAPS       = 9,
  parameter int          ROW_W      = 10,
  parameter int          ROW_WINDOW = 1024,
  parameter logic [9:0]  ALU_RESET  = 10'h018
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cfgStrobe_t               strb,
  input  logic [DATA_W-1:0]        wrData,
  output logic [ROW_W-1:0]         rowLen,
  output logic [DATA_W-1:0]        aluCode,
  output logic [INIT_W-1:0]        initWord,
  output logic                     bankSel,
  output logic [TAPS*COEF_W-1:0]   coefFlat
);

  localparam int BANKS = 2;
  localparam int IDX_W = $clog2(TAPS);
  localparam int CNT_W = $clog2(ROW_WINDOW + 1);

  logic [CNT_W-1:0]  winCnt;
  logic              windowOpen;
  logic              rowTaken;
  logic [IDX_W-1:0]  tapIdx   [BANKS];
  logic [COEF_W-1:0] coefBank [BANKS][TAPS];

  assign windowOpen = winCnt < CNT_W'(ROW_WINDOW);

  // Row length: single load inside the post-reset window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt   <= '0;
      rowTaken <= 1'b0;
      rowLen   <= '0;
    end else begin
      if (windowOpen) winCnt <= winCnt + 1'b1;
      if (strb.wrRow && windowOpen && !rowTaken) begin
        rowLen   <= wrData[ROW_W-1:0];
        rowTaken <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aluCode  <= ALU_RESET[DATA_W-1:0];
      initWord <= '0;
    end else begin
      if (strb.wrAlu)  aluCode  <= wrData;
      if (strb.wrInit) initWord <= wrData[INIT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 bankSel <= 1'b0;
    else if (strb.selBank[0])  bankSel <= 1'b0;
    else if (strb.selBank[1])  bankSel <= 1'b1;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tapIdx[b] <= '0;
      end else if (strb.wrBank[b]) begin
        tapIdx[b] <= (tapIdx[b] == IDX_W'(TAPS - 1)) ? '0 : tapIdx[b] + 1'b1;
      end else if (strb.wrBank[BANKS-1-b]) begin
        tapIdx[b] <= '0;
      end
    end

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          coefBank[b][t] <= '0;
        else if (strb.wrBank[b] && tapIdx[b] == IDX_W'(t))
          coefBank[b][t] <= wrData[COEF_W-1:0];
      end
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_out
    assign coefFlat[t*COEF_W +: COEF_W] = bankSel ? coefBank[1][t] : coefBank[0][t];
  end

endmodule

// File: rtl/conv_cfg_regfile.sv
module conv_cfg_regfile
  import cfg_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int COEF_W     = 8,
  parameter int TAPS       = 9,
  parameter int ROW_W      = 10,
  parameter int ROW_WINDOW = 1024
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2:0]             hostAddr,
  input  logic [DATA_W-1:0]      hostData,
  input  logic                   hostSel,
  input  logic                   hostLoad,
  output logic [ROW_W-1:0]       rowLen,
  output logic [DATA_W-1:0]      aluCode,
  output logic                   extLineMode,
  output logic [1:0]             inDelay,
  output logic                   pixSigned,
  output logic                   coefSigned,
  output logic [1:0]             roundMode,
  output logic [1:0]             casShift,
  output logic                   bankSel,
  output logic [TAPS*COEF_W-1:0] coefActive
);

  cfgStrobe_t          strb;
  logic [DATA_W-1:0]   wrData;
  logic [INIT_W-1:0]   initWord;

  cfg_host_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostAddr (hostAddr),
    .hostData (hostData),
    .hostSel  (hostSel),
    .hostLoad (hostLoad),
    .strb     (strb),
    .wrData   (wrData)
  );

  cfg_reg_store #(
    .DATA_W     (DATA_W),
    .COEF_W     (COEF_W),
    .TAPS       (TAPS),
    .ROW_W      (ROW_W),
    .ROW_WINDOW (ROW_WINDOW)
  ) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .rowLen   (rowLen),
    .aluCode  (aluCode),
    .initWord (initWord),
    .bankSel  (bankSel),
    .coefFlat (coefActive)
  );

  assign extLineMode = initWord[0];
  assign inDelay     = initWord[2:1];
  assign pixSigned   = initWord[3];
  assign coefSigned  = initWord[4];
  assign roundMode   = initWord[6:5];
  assign casShift    = initWord[8:7];

endmodule

// File: rtl/cfg_regfile_chk.sv
module cfg_regfile_chk
  import cfg_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int ROW_W      = 10,
  parameter int ROW_WINDOW = 1024
) (
  input logic              clk,
  input logic              rstN,
  input cfgStrobe_t        strb,
  input logic [ROW_W-1:0]  rowLen,
  input logic [DATA_W-1:0] aluCode,
  input logic              bankSel
);

  localparam int CNT_W = $clog2(ROW_WINDOW + 2);

  logic [CNT_W-1:0] edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               edgeCnt <= '0;
    else if (edgeCnt < CNT_W'(ROW_WINDOW + 1)) edgeCnt <= edgeCnt + 1'b1;
  end

  // R2: at most one register action per committed write
  a_r2_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R3: the ALU command moves only after an ALU write strobe
  a_r3_alu_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(aluCode) |-> $past(strb.wrAlu));

  // R6: bank selection takes effect on the next clock
  a_r6_sel_one: assert property (@(posedge clk) disable iff (!rstN)
    strb.selBank[1] |=> bankSel);

  a_r6_sel_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.selBank[0] |=> !bankSel);

  a_r6_bank_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bankSel) |-> $past(strb.selBank != 2'b00));

  // R7: row length frozen once the window has closed
  a_r7_row_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt >= CNT_W'(ROW_WINDOW)) |=> $stable(rowLen));

endmodule

bind conv_cfg_regfile cfg_regfile_chk #(
  .DATA_W     (DATA_W),
  .ROW_W      (ROW_W),
  .ROW_WINDOW (ROW_WINDOW)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .strb    (strb),
  .rowLen  (rowLen),
  .aluCode (aluCode),
  .bankSel (bankSel)
);

// File: tb/sim_conv_cfg_regfile.sv
module sim_conv_cfg_regfile;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [9:0]  hostData = '0;
  logic        hostSel = 1'b0;
  logic        hostLoad = 1'b0;
  logic [9:0]  rowLen;
  logic [9:0]  aluCode;
  logic        extLineMode;
  logic [1:0]  inDelay;
  logic        pixSigned;
  logic        coefSigned;
  logic [1:0]  roundMode;
  logic [1:0]  casShift;
  logic        bankSel;
  logic [71:0] coefActive;

  int checks = 0;
  int errors = 0;
  int edgeNo;

  logic [7:0] m0 [9];
  logic [7:0] m1 [9];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rstN)
    if (!rstN) edgeNo <= 0;
    else       edgeNo <= edgeNo + 1;

  conv_cfg_regfile u0 (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostData(hostData),
    .hostSel(hostSel), .hostLoad(hostLoad), .rowLen(rowLen), .aluCode(aluCode),
    .extLineMode(extLineMode), .inDelay(inDelay), .pixSigned(pixSigned),
    .coefSigned(coefSigned), .roundMode(roundMode), .casShift(casShift),
    .bankSel(bankSel), .coefActive(coefActive)
  );

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [71:0] packBank(input bit which);
    logic [71:0] v;
    for (int t = 0; t < 9; t++) v[t*8 +: 8] = which ? m1[t] : m0[t];
    return v;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    hostLoad = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int t = 0; t < 9; t++) begin
      m0[t] = 8'h00;
      m1[t] = 8'h00;
    end
  endtask

  // Commit lands on the given edge number counted from reset release
  task automatic writeAt(input logic [2:0] a, input logic [9:0] d, input bit cs, input int commit);
    while (edgeNo != commit - 6) @(negedge clk);
    hostAddr = a; hostData = d; hostSel = cs; hostLoad = 1'b1;
    while (edgeNo != commit - 3) @(negedge clk);
    hostLoad = 1'b0;
    while (edgeNo != commit + 1) @(negedge clk);
    hostSel = 1'b0;
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [9:0] d, input bit cs = 1'b1);
    @(negedge clk);
    writeAt(a, d, cs, edgeNo + 6);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [71:0] snap;
    doReset();
    @(negedge clk);
    // R1 reset state
    chk("R1 rowLen", 72'(rowLen), 72'd0);
    chk("R1 aluCode", 72'(aluCode), 72'h018);
    chk("R1 init", 72'({casShift, roundMode, coefSigned, pixSigned, inDelay, extLineMode}), 72'd0);
    chk("R1 bankSel", 72'(bankSel), 72'd0);
    chk("R1 coef", coefActive, 72'd0);

    // R3 ALU command load; R2 chip select low blocks it
    doWrite(3'd1, 10'h2C5);
    chk("R3 alu write", 72'(aluCode), 72'h2C5);
    doWrite(3'd1, 10'h0F0, 1'b0);
    chk("R2 no chip select", 72'(aluCode), 72'h2C5);

    // R3/R8 init word 9'b11_01_0_1_10_1 = 429
    doWrite(3'd4, 10'd429);
    chk("R8 extLineMode", 72'(extLineMode), 72'd1);
    chk("R8 inDelay", 72'(inDelay), 72'd2);
    chk("R8 pixSigned", 72'(pixSigned), 72'd1);
    chk("R8 coefSigned", 72'(coefSigned), 72'd0);
    chk("R8 roundMode", 72'(roundMode), 72'd1);
    chk("R8 casShift", 72'(casShift), 72'd3);
    doWrite(3'd4, 10'd18);
    chk("R3 init reload", 72'({casShift, roundMode, coefSigned, pixSigned, inDelay, extLineMode}), 72'd18);

    // R7 first row-length write kept, second ignored
    doWrite(3'd0, 10'd37);
    chk("R7 first row write", 72'(rowLen), 72'd37);
    doWrite(3'd0, 10'd55);
    chk("R7 second row write ignored", 72'(rowLen), 72'd37);

    // R4 bank 0 fill A..I
    for (int k = 0; k < 9; k++) begin
      m0[k] = 8'(8'h10 + k * 7);
      doWrite(3'd2, {2'b11, m0[k]});
    end
    chk("R4 bank0 fill", coefActive, packBank(1'b0));
    // R4 bank 1 fill with wrap: tenth write lands on A
    for (int k = 0; k < 9; k++) begin
      m1[k] = 8'(8'hF0 - k);
      doWrite(3'd3, {2'b00, m1[k]});
    end
    m1[0] = 8'hAA;
    doWrite(3'd3, 10'h0AA);
    chk("R6 bank0 still active", coefActive, packBank(1'b0));
    doWrite(3'd6, 10'h000);
    chk("R6 select bank1", 72'(bankSel), 72'd1);
    chk("R4 bank1 wrap", coefActive, packBank(1'b1));

    // R5 other-bank pointer reset
    doWrite(3'd2, 10'h05A); m0[0] = 8'h5A;
    doWrite(3'd2, 10'h05B); m0[1] = 8'h5B;
    doWrite(3'd3, 10'h011); m1[0] = 8'h11;
    doWrite(3'd2, 10'h077); m0[0] = 8'h77;
    chk("R5 bank1 pointer reset", coefActive, packBank(1'b1));
    doWrite(3'd5, 10'h000);
    chk("R6 select bank0", 72'(bankSel), 72'd0);
    chk("R5 bank0 pointer reset", coefActive, packBank(1'b0));

    // R9 no-op address
    snap = coefActive;
    doWrite(3'd7, 10'h3FF);
    chk("R9 nop coef", coefActive, snap);
    chk("R9 nop alu", 72'(aluCode), 72'h2C5);
    chk("R9 nop row", 72'(rowLen), 72'd37);
    chk("R9 nop bank", 72'(bankSel), 72'd0);
    chk("R9 nop init", 72'({casShift, roundMode, coefSigned, pixSigned, inDelay, extLineMode}), 72'd18);

    // R7 after window still held
    writeAt(3'd0, 10'd99, 1'b1, WIN + 20);
    chk("R7 after window", 72'(rowLen), 72'd37);

    // R7 boundary: commit on last window edge
    doReset();
    writeAt(3'd0, 10'd300, 1'b1, WIN);
    chk("R7 commit on edge 1024", 72'(rowLen), 72'd300);
    chk("R1 alu after reset", 72'(aluCode), 72'h018);

    // R7 boundary: one edge late
    doReset();
    writeAt(3'd0, 10'd300, 1'b1, WIN + 1);
    chk("R7 commit on edge 1025", 72'(rowLen), 72'd0);
    chk("R1 coef after reset", coefActive, 72'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule